// File: doc/BRIEF.md
# Signed Up/Down Counter with Preset-Match Interrupt

This block is the counting core of a high-speed event counter. An upstream decoder turns quadrature, pulse/direction or separate up/down input signals into one-cycle increment and decrement strobes. The core turns those strobes into a 32-bit signed current value. It holds a preset value loaded by the host, and it raises a one-cycle interrupt pulse at the moment the current value first equals the preset. The interrupt has no added latency, so firmware can reload the preset from its service routine for repeated or multi-zone positioning.

Each of the two gating functions, mask and clear, combines a hardware pin with a software bit. Each hardware pin has its own polarity-invert bit, so an inverted mask pin acts as an active-high enable from a sensor. The host can load both registers and can read the current value at any time. A separate enable/disable control gates only the interrupt: counting goes on while the interrupt is disabled.

Top module: `upd_match_counter`

## Requirements
- R1: After reset the current value and the preset are both 0, the interrupt output is low and the interrupt is enabled.
- R2: With mask and clear inactive and no host CV write, an increment strobe adds 1 to the current value and a decrement strobe subtracts 1. Both strobes in the same cycle leave the value unchanged. The result appears on `cv_out` one clock after the strobe.
- R3: A host write with `wr_cv` (or `wr_pv`) loads `wdata` into the current value (or the preset) on the next clock. `cv_out` always shows the current value.
- R4: The effective mask is (`hw_mask` XOR `mask_inv`) OR `sw_mask`. While it is 1, strobes and host writes to either register are ignored, and the current value and the preset hold.
- R5: The effective clear is (`hw_clear` XOR `clear_inv`) OR `sw_clear`. While it is 1, the current value is forced to 0 on each clock. Counting resumes from 0 once clear is released.
- R6: The current value is decided in this order: clear first, then mask, then a host CV write, then counting.
- R7: `irq` is high, with no register delay, in the first cycle in which `cv_out` equals the preset (after counting or after a write to either register). It is high for one cycle only, even while the two values stay equal.
- R8: A `irq_dis` pulse disables the interrupt and a `irq_ena` pulse enables it again. If both come in the same cycle, disable wins. While disabled, counting goes on and no pulse is issued. Enabling while the values are already equal issues no pulse.
- R9: The current value wraps in two's complement: 0x7FFFFFFF plus 1 gives 0x80000000, and 0 minus 1 gives 0xFFFFFFFF.
- R10: The equality of both registers at 0 that holds straight after reset does not issue a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| inc_stb | input | 1 | Increment strobe from the decoder |
| dec_stb | input | 1 | Decrement strobe from the decoder |
| hw_mask | input | 1 | Hardware mask pin |
| sw_mask | input | 1 | Software mask bit |
| mask_inv | input | 1 | Inverts the polarity of `hw_mask` |
| hw_clear | input | 1 | Hardware clear pin |
| sw_clear | input | 1 | Software clear bit |
| clear_inv | input | 1 | Inverts the polarity of `hw_clear` |
| wr_cv | input | 1 | Host write strobe for the current value |
| wr_pv | input | 1 | Host write strobe for the preset |
| wdata | input | 32 | Host write data |
| irq_ena | input | 1 | Pulse that enables the interrupt |
| irq_dis | input | 1 | Pulse that disables the interrupt |
| cv_out | output | 32 | Current value readback |
| irq | output | 1 | Preset-match interrupt pulse |

## Verification
The assertions take every input to be synchronous to `clk`, settled before each rising edge and held for a whole cycle. They also take a strobe to mean one event per cycle in which it is high. The bench drives all inputs at the falling edge. It holds them for exactly one period and returns them to idle, so every strobe and write pulse is a clean one-cycle event. Mask, clear and their polarity bits are kept low for long stretches of random traffic, and preset writes are aimed close to the current value, so that the count runs long enough to reach a match.

// File: rtl/upd_cnt_pkg.sv
package upd_cnt_pkg;
  // What the current-value register does in a cycle, listed in priority order
  typedef enum logic [1:0] {
    CV_ACT_COUNT = 2'd0,
    CV_ACT_LOAD  = 2'd1,
    CV_ACT_HOLD  = 2'd2,
    CV_ACT_ZERO  = 2'd3
  } cv_act_e;
endpackage

// File: rtl/upd_rst_sync.sv
module upd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/upd_ctrl_resolve.sv
module upd_ctrl_resolve
  import upd_cnt_pkg::*;
(
  input  logic    hw_mask,
  input  logic    sw_mask,
  input  logic    mask_inv,
  input  logic    hw_clear,
  input  logic    sw_clear,
  input  logic    clear_inv,
  input  logic    wr_cv,
  output logic    eff_mask,
  output logic    eff_clear,
  output cv_act_e cv_act
);
  always_comb begin
    eff_mask  = (hw_mask ^ mask_inv) | sw_mask;
    eff_clear = (hw_clear ^ clear_inv) | sw_clear;
    if (eff_clear)     cv_act = CV_ACT_ZERO;
    else if (eff_mask) cv_act = CV_ACT_HOLD;
    else if (wr_cv)    cv_act = CV_ACT_LOAD;
    else               cv_act = CV_ACT_COUNT;
  end
endmodule

// File: rtl/upd_value_regs.sv
module upd_value_regs
  import upd_cnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cv_act_e      cv_act,
  input  logic         eff_mask,
  input  logic         eff_clear,
  input  logic         inc_stb,
  input  logic         dec_stb,
  input  logic         wr_pv,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cv,
  output logic [W-1:0] pv
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cv_q, cv_nxt, pv_q, pv_nxt;
  logic         cv_ce, pv_ce;

  always_comb begin
    cv_nxt = cv_q;
    cv_ce  = 1'b0;
    unique case (cv_act)
      CV_ACT_ZERO: begin cv_nxt = '0; cv_ce = 1'b1; end
      CV_ACT_HOLD: begin cv_nxt = cv_q; cv_ce = 1'b0; end
      CV_ACT_LOAD: begin cv_nxt = wdata; cv_ce = 1'b1; end
      default: begin
        cv_ce = inc_stb ^ dec_stb;
        cv_nxt = inc_stb ? (cv_q + ONE) : (cv_q - ONE);
      end
    endcase
    pv_ce  = wr_pv & ~eff_mask;
    pv_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cv_q <= '0;
    else if (cv_ce) cv_q <= cv_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pv_q <= '0;
    else if (pv_ce) pv_q <= pv_nxt;
  end

  assign cv = cv_q;
  assign pv = pv_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_clear |=> (cv == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mask && !eff_clear) |=> ($stable(cv) && $stable(pv)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_mask && !eff_clear && cv_act == CV_ACT_COUNT && inc_stb && !dec_stb)
      |=> (cv == $past(cv) + ONE));

  // R3
  pv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pv && !eff_mask) |=> (pv == $past(wdata)));
endmodule

// File: rtl/upd_match_irq.sv
module upd_match_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cv,
  input  logic [W-1:0] pv,
  input  logic         irq_ena,
  input  logic         irq_dis,
  output logic         irq
);
  logic en_q, en_nxt, eq_q, eq_now;

  always_comb begin
    eq_now = (cv == pv);
    if (irq_dis)      en_nxt = 1'b0;
    else if (irq_ena) en_nxt = 1'b1;
    else              en_nxt = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
      eq_q <= 1'b1;
    end else begin
      en_q <= en_nxt;
      eq_q <= eq_now;
    end
  end

  assign irq = en_q & eq_now & ~eq_q;

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dis |=> !irq);
endmodule

// File: rtl/upd_match_counter.sv
module upd_match_counter
  import upd_cnt_pkg::*;
#(
  parameter int W          = 32,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_stb,
  input  logic         dec_stb,
  input  logic         hw_mask,
  input  logic         sw_mask,
  input  logic         mask_inv,
  input  logic         hw_clear,
  input  logic         sw_clear,
  input  logic         clear_inv,
  input  logic         wr_cv,
  input  logic         wr_pv,
  input  logic [W-1:0] wdata,
  input  logic         irq_ena,
  input  logic         irq_dis,
  output logic [W-1:0] cv_out,
  output logic         irq
);
  logic         rst_int_n;
  logic         eff_mask, eff_clear;
  cv_act_e      cv_act;
  logic [W-1:0] cv, pv;

  upd_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  upd_ctrl_resolve u_ctrl (
    .hw_mask(hw_mask), .sw_mask(sw_mask), .mask_inv(mask_inv),
    .hw_clear(hw_clear), .sw_clear(sw_clear), .clear_inv(clear_inv),
    .wr_cv(wr_cv), .eff_mask(eff_mask), .eff_clear(eff_clear), .cv_act(cv_act)
  );

  upd_value_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cv_act(cv_act),
    .eff_mask(eff_mask), .eff_clear(eff_clear),
    .inc_stb(inc_stb), .dec_stb(dec_stb), .wr_pv(wr_pv), .wdata(wdata),
    .cv(cv), .pv(pv)
  );

  upd_match_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .cv(cv), .pv(pv),
    .irq_ena(irq_ena), .irq_dis(irq_dis), .irq(irq)
  );

  assign cv_out = cv;
endmodule

// File: tb/tb_upd_match_counter.sv
module tb_upd_match_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inc_stb, dec_stb, hw_mask, sw_mask, mask_inv;
  logic        hw_clear, sw_clear, clear_inv, wr_cv, wr_pv, irq_ena, irq_dis;
  logic [31:0] wdata;
  logic [31:0] cv_out;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [31:0] m_cv, m_pv;
  bit          m_en, m_prev_eq;

  always #10 clk = ~clk;

  upd_match_counter dut (
    .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .dec_stb(dec_stb),
    .hw_mask(hw_mask), .sw_mask(sw_mask), .mask_inv(mask_inv),
    .hw_clear(hw_clear), .sw_clear(sw_clear), .clear_inv(clear_inv),
    .wr_cv(wr_cv), .wr_pv(wr_pv), .wdata(wdata),
    .irq_ena(irq_ena), .irq_dis(irq_dis), .cv_out(cv_out), .irq(irq)
  );

  task automatic idle();
    inc_stb = 0; dec_stb = 0; hw_mask = 0; sw_mask = 0; mask_inv = 0;
    hw_clear = 0; sw_clear = 0; clear_inv = 0; wr_cv = 0; wr_pv = 0;
    irq_ena = 0; irq_dis = 0; wdata = '0;
  endtask

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit exp_irq;
    exp_irq = m_en && (m_cv == m_pv) && !m_prev_eq;
    expect32({tag, " cv_out"}, cv_out, m_cv);
    expect32({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
  endtask

  task automatic model_update();
    bit em, ec, eq_now;
    em = (hw_mask ^ mask_inv) | sw_mask;
    ec = (hw_clear ^ clear_inv) | sw_clear;
    eq_now = (m_cv == m_pv);
    if (irq_dis) m_en = 0;
    else if (irq_ena) m_en = 1;
    if (ec) m_cv = '0;
    else if (em) m_cv = m_cv;
    else if (wr_cv) m_cv = wdata;
    else if (inc_stb && !dec_stb) m_cv = m_cv + 32'd1;
    else if (dec_stb && !inc_stb) m_cv = m_cv - 32'd1;
    if (wr_pv && !em) m_pv = wdata;
    m_prev_eq = eq_now;
  endtask

  // Caller sets inputs after a falling edge; this compares, advances the model, waits one period.
  task automatic step(string tag);
    compare(tag);
    model_update();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    m_cv = '0; m_pv = '0; m_en = 1; m_prev_eq = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 / R10: reset state, no pulse from the equal zero registers
    expect32("R1 cv after reset", cv_out, 32'd0);
    expect32("R10 irq after reset", {31'b0, irq}, 32'd0);
    step("R1");

    // R3: host loads
    wr_pv = 1; wdata = 32'd5; step("R3 pv write");
    wr_cv = 1; wdata = 32'd3; step("R3 cv write");
    expect32("R3 cv loaded", cv_out, 32'd3);
    // R2 and R7: count up into match
    inc_stb = 1; step("R2 inc");
    inc_stb = 1; step("R2 inc");
    expect32("R7 irq on match", {31'b0, irq}, 32'd1);
    step("R7 match cycle");
    expect32("R7 single pulse", {31'b0, irq}, 32'd0);
    inc_stb = 1; dec_stb = 1; step("R2 both");
    dec_stb = 1; step("R2 dec");
    expect32("R2 after dec", cv_out, 32'd4);
    inc_stb = 1; step("R7 rematch");
    step("R7");

    // R4: mask variants
    hw_mask = 1; inc_stb = 1; wr_pv = 1; wdata = 32'd99; step("R4 hw mask");
    sw_mask = 1; wr_cv = 1; wdata = 32'd77; step("R4 sw mask");
    mask_inv = 1; inc_stb = 1; step("R4 inverted mask low");
    expect32("R4 held", cv_out, 32'd5);
    mask_inv = 1; hw_mask = 1; inc_stb = 1; step("R4 inverted mask high");
    expect32("R4 enable counts", cv_out, 32'd6);

    // R5: clear variants
    hw_clear = 1; inc_stb = 1; step("R5 hw clear");
    expect32("R5 cleared", cv_out, 32'd0);
    inc_stb = 1; step("R5 resume");
    expect32("R5 from zero", cv_out, 32'd1);
    clear_inv = 1; step("R5 inverted clear");
    sw_clear = 1; wr_pv = 1; wdata = 32'd2; step("R5 sw clear");

    // R6: priority
    wr_cv = 1; wdata = 32'd40; step("R6 load");
    hw_clear = 1; hw_mask = 1; wr_cv = 1; wdata = 32'd9; inc_stb = 1; step("R6 clear wins");
    expect32("R6 clear over all", cv_out, 32'd0);
    wr_cv = 1; wdata = 32'd20; step("R6 prep");
    sw_mask = 1; wr_cv = 1; wdata = 32'd9; step("R6 mask over write");
    expect32("R6 mask held", cv_out, 32'd20);
    wr_cv = 1; wdata = 32'd30; inc_stb = 1; step("R6 write over count");
    expect32("R6 write won", cv_out, 32'd30);

    // R8: disable gates only the interrupt
    wr_pv = 1; wdata = 32'd32; irq_dis = 1; step("R8 disable");
    inc_stb = 1; step("R8 count");
    inc_stb = 1; step("R8 count into match");
    expect32("R8 counting continues", cv_out, 32'd32);
    expect32("R8 no irq", {31'b0, irq}, 32'd0);
    irq_ena = 1; step("R8 enable while equal");
    step("R8 no late pulse");
    irq_ena = 1; irq_dis = 1; dec_stb = 1; step("R8 both");
    inc_stb = 1; step("R8 disable won");
    expect32("R8 disable priority", {31'b0, irq}, 32'd0);
    irq_ena = 1; dec_stb = 1; step("R8 reenable");
    inc_stb = 1; step("R8 fires again");

    // R9: wrap
    wr_cv = 1; wdata = 32'h7FFF_FFFF; step("R9 load max");
    inc_stb = 1; step("R9 overflow");
    expect32("R9 overflow", cv_out, 32'h8000_0000);
    wr_cv = 1; wdata = 32'd0; step("R9 load zero");
    dec_stb = 1; step("R9 underflow");
    expect32("R9 underflow", cv_out, 32'hFFFF_FFFF);
    step("R9");

    // Random traffic compared every clock (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      inc_stb = ($urandom_range(0, 2) == 0);
      dec_stb = ($urandom_range(0, 3) == 0);
      if (r < 3) hw_mask = 1;
      else if (r < 5) sw_mask = 1;
      else if (r < 7) hw_clear = 1;
      else if (r < 8) sw_clear = 1;
      else if (r < 9) begin mask_inv = 1; hw_mask = $urandom_range(0, 1); end
      else if (r < 10) begin clear_inv = 1; hw_clear = 1; end
      else if (r < 13) begin wr_pv = 1; wdata = m_cv + 32'($urandom_range(0, 6)) - 32'd3; end
      else if (r < 15) begin wr_cv = 1; wdata = m_pv - 32'($urandom_range(0, 4)); end
      else if (r < 17) irq_dis = 1;
      else if (r < 20) irq_ena = 1;
      step("R2-R8 random R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule